// File: doc/BRIEF.md
# I2S master audio transceiver

This block is the clock master of a two-channel serial audio link. It divides the system clock down to a bit clock, drives a word-select line that marks the left and right halves of each frame, and serialises one left and one right sample per frame onto the data output. At the same time it deserialises the two samples that arrive on the data input and presents them as a pair in parallel.

A frame is 64 bit-clock periods long: 32 for the left channel (word select low), then 32 for the right channel (word select high). A runtime format input chooses where the most significant bit sits in a slot. In I2S format it sits one bit-clock period after the word-select edge. In left-justified format it sits in the period that starts at that edge. A 2-bit width code sets how many bits of each slot carry data. Software loads a new left/right pair at any time into a holding stage. The block copies that stage into its shifters when a left data slot begins and signals that moment. If no new pair was loaded, the previous pair is sent again.

Top module: `i2s_master_xcvr`

## Requirements
- R1: While reset is asserted, the bit clock and word select are high, and the serial data output, the frame request and the receive valid strobe are low.
- R2: Each half period of the bit clock lasts `div_i + 1` system clock cycles, so one bit-clock period is `2*(div_i+1)` cycles.
- R3: Word select and serial data output change only in the cycle in which the bit clock falls. The serial input is sampled in the cycle in which the bit clock rises.
- R4: Word select stays low for 32 bit-clock periods (left slot), then high for 32 periods (right slot), and alternates in this way.
- R5: The width code selects 8, 16, 24 or 32 data bits per slot for codes 0, 1, 2 and 3. The bits sent are the low W bits of each transmit word, most significant bit (bit W-1) first.
- R6: With `fmt_i` = 0 (I2S), the most significant bit of a slot's word is driven in the second bit-clock period after the word-select transition.
- R7: With `fmt_i` = 1 (left-justified), the most significant bit is driven in the first bit-clock period after the word-select transition.
- R8: Every bit-clock period of a slot after the word's least significant bit is driven low.
- R9: A pulse on `tx_load_i` stores both transmit words. At the start of each left data slot the stored pair moves into the shifters, and `tx_req_o` pulses for one cycle while word select is low. If no load happened in between, the same pair is sent again.
- R10: The received words appear right-aligned and zero-extended in their low W bits. `rx_valid_o` is high for one cycle, one cycle after the right word's least significant bit is sampled, and `rx_left_o` then holds the left word of the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Bit-clock half period minus one, in system cycles |
| fmt_i | input | 1 | 0: I2S format, 1: left-justified format |
| width_i | input | 2 | Data bits per slot: 0=8, 1=16, 2=24, 3=32 |
| tx_left_i | input | 32 | Left transmit word (low W bits used) |
| tx_right_i | input | 32 | Right transmit word (low W bits used) |
| tx_load_i | input | 1 | Store the transmit pair in the holding stage |
| sdi_i | input | 1 | Serial data input |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, low = left, high = right |
| sdo_o | output | 1 | Serial data output |
| tx_req_o | output | 1 | One-cycle pulse: held pair taken for a new frame |
| rx_left_o | output | 32 | Last received left word |
| rx_right_o | output | 32 | Last received right word |
| rx_valid_o | output | 1 | One-cycle pulse: new received pair |

## Verification
The bench loops `sdo_o` back to `sdi_i`. It predicts each frame's words at the `tx_req_o` pulse, which is one system cycle after the falling bit-clock edge that starts the left data slot. The serial line is decoded on each rising bit-clock edge, half a bit period after data and word select last changed. That decoder places bits from its own count of periods since the word-select edge, so a shifted MSB position or missing zero padding is caught independently of the receiver. The received pair is checked on the cycle after the rising edge that sampled the right LSB, at the `rx_valid_o` pulse. The bit-clock period is checked by counting system cycles between two rising edges.

// File: rtl/i2s_xcvr_pkg.sv
package i2s_xcvr_pkg;

    localparam int SLOT_BITS  = 32;
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int IDX_W      = $clog2(SLOT_BITS);

    typedef enum logic {
        FMT_I2S       = 1'b0,
        FMT_LEFT_JUST = 1'b1
    } fmt_e;

    // Number of data bits per slot for a width code.
    function automatic logic [IDX_W:0] word_len(input logic [1:0] code);
        case (code)
            2'd0:    return (IDX_W+1)'(8);
            2'd1:    return (IDX_W+1)'(16);
            2'd2:    return (IDX_W+1)'(24);
            default: return (IDX_W+1)'(32);
        endcase
    endfunction

endpackage

// File: rtl/i2s_bclk_div.sv
module i2s_bclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             bclk_o,
    output logic             rise_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             bclk;
    } div_st_t;

    localparam div_st_t DIV_RST = '{cnt: '0, bclk: 1'b1};

    div_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        rise_o = 1'b0;
        fall_o = 1'b0;
        if (st_q.cnt >= div_i) begin
            st_d.cnt  = '0;
            st_d.bclk = ~st_q.bclk;
            rise_o    = ~st_q.bclk;
            fall_o    = st_q.bclk;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DIV_RST;
        else        st_q <= st_d;
    end

    assign bclk_o = st_q.bclk;

endmodule

// File: rtl/i2s_frame_seq.sv
module i2s_frame_seq
    import i2s_xcvr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic             fmt_i,
    output logic             ws_o,
    output logic [POS_W-1:0] eff_now_o,
    output logic [POS_W-1:0] eff_next_o,
    output logic             slot_start_o
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } seq_st_t;

    localparam seq_st_t SEQ_RST = '{pos: '1};

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fall_i) st_d.pos = st_q.pos + 1'b1;
        // Data position lags the word-select position by one period in I2S format.
        if (fmt_i == FMT_I2S) begin
            eff_now_o  = st_q.pos - 1'b1;
            eff_next_o = st_d.pos - 1'b1;
        end else begin
            eff_now_o  = st_q.pos;
            eff_next_o = st_d.pos;
        end
        slot_start_o = fall_i && (eff_next_o == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_RST;
        else        st_q <= st_d;
    end

    assign ws_o = st_q.pos[POS_W-1];

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
    import i2s_xcvr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [SLOT_BITS-1:0] left_i,
    input  logic [SLOT_BITS-1:0] right_i,
    input  logic                 fall_i,
    input  logic                 slot_start_i,
    input  logic [POS_W-1:0]     eff_i,
    input  logic [1:0]           wcode_i,
    output logic                 sdo_o,
    output logic                 req_o
);

    typedef struct packed {
        logic [SLOT_BITS-1:0] pend_l;
        logic [SLOT_BITS-1:0] pend_r;
        logic [SLOT_BITS-1:0] act_l;
        logic [SLOT_BITS-1:0] act_r;
        logic                 sdo;
        logic                 req;
    } tx_st_t;

    localparam tx_st_t TX_RST = '{default: '0};

    tx_st_t st_d, st_q;

    logic [IDX_W:0]       len_v;
    logic [IDX_W:0]       idx_v;
    logic [IDX_W-1:0]     j_v;
    logic [SLOT_BITS-1:0] word_v;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        len_v    = word_len(wcode_i);
        j_v      = eff_i[IDX_W-1:0];
        idx_v    = len_v - 1'b1 - {1'b0, j_v};
        word_v   = '0;

        if (load_i) begin
            st_d.pend_l = left_i;
            st_d.pend_r = right_i;
        end

        if (fall_i) begin
            if (slot_start_i) begin
                st_d.act_l = st_q.pend_l;
                st_d.act_r = st_q.pend_r;
                st_d.req   = 1'b1;
            end
            word_v = eff_i[POS_W-1] ? st_d.act_r : st_d.act_l;
            if ({1'b0, j_v} < len_v) st_d.sdo = word_v[idx_v[IDX_W-1:0]];
            else                     st_d.sdo = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_RST;
        else        st_q <= st_d;
    end

    assign sdo_o = st_q.sdo;
    assign req_o = st_q.req;

endmodule

// File: rtl/i2s_rx_deserializer.sv
module i2s_rx_deserializer
    import i2s_xcvr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise_i,
    input  logic                 sdi_i,
    input  logic [POS_W-1:0]     eff_i,
    input  logic [1:0]           wcode_i,
    output logic [SLOT_BITS-1:0] left_o,
    output logic [SLOT_BITS-1:0] right_o,
    output logic                 valid_o
);

    typedef struct packed {
        logic [SLOT_BITS-1:0] sr;
        logic [SLOT_BITS-1:0] hold_l;
        logic [SLOT_BITS-1:0] out_l;
        logic [SLOT_BITS-1:0] out_r;
        logic                 valid;
    } rx_st_t;

    localparam rx_st_t RX_RST = '{default: '0};

    rx_st_t st_d, st_q;

    logic [IDX_W:0]       len_v;
    logic [IDX_W-1:0]     j_v;
    logic                 ch_v;
    logic [SLOT_BITS-1:0] shift_v;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        len_v      = word_len(wcode_i);
        j_v        = eff_i[IDX_W-1:0];
        ch_v       = eff_i[POS_W-1];
        if (j_v == '0) shift_v = {{(SLOT_BITS-1){1'b0}}, sdi_i};
        else           shift_v = {st_q.sr[SLOT_BITS-2:0], sdi_i};

        if (rise_i && ({1'b0, j_v} < len_v)) begin
            st_d.sr = shift_v;
            if ({1'b0, j_v} == len_v - 1'b1) begin
                if (!ch_v) begin
                    st_d.hold_l = shift_v;
                end else begin
                    st_d.out_l = st_q.hold_l;
                    st_d.out_r = shift_v;
                    st_d.valid = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_RST;
        else        st_q <= st_d;
    end

    assign left_o  = st_q.out_l;
    assign right_o = st_q.out_r;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/i2s_master_xcvr.sv
module i2s_master_xcvr
    import i2s_xcvr_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     div_i,
    input  logic                 fmt_i,
    input  logic [1:0]           width_i,
    input  logic [SLOT_BITS-1:0] tx_left_i,
    input  logic [SLOT_BITS-1:0] tx_right_i,
    input  logic                 tx_load_i,
    input  logic                 sdi_i,
    output logic                 bclk_o,
    output logic                 ws_o,
    output logic                 sdo_o,
    output logic                 tx_req_o,
    output logic [SLOT_BITS-1:0] rx_left_o,
    output logic [SLOT_BITS-1:0] rx_right_o,
    output logic                 rx_valid_o
);

    logic             rise_w;
    logic             fall_w;
    logic [POS_W-1:0] eff_now_w;
    logic [POS_W-1:0] eff_next_w;
    logic             slot_start_w;

    i2s_bclk_div #(.DIV_W(DIV_W)) div_u (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_i),
        .bclk_o (bclk_o),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    i2s_frame_seq seq_u (
        .clk          (clk),
        .rst_n        (rst_n),
        .fall_i       (fall_w),
        .fmt_i        (fmt_i),
        .ws_o         (ws_o),
        .eff_now_o    (eff_now_w),
        .eff_next_o   (eff_next_w),
        .slot_start_o (slot_start_w)
    );

    i2s_tx_serializer tx_u (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (tx_load_i),
        .left_i       (tx_left_i),
        .right_i      (tx_right_i),
        .fall_i       (fall_w),
        .slot_start_i (slot_start_w),
        .eff_i        (eff_next_w),
        .wcode_i      (width_i),
        .sdo_o        (sdo_o),
        .req_o        (tx_req_o)
    );

    i2s_rx_deserializer rx_u (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise_w),
        .sdi_i   (sdi_i),
        .eff_i   (eff_now_w),
        .wcode_i (width_i),
        .left_o  (rx_left_o),
        .right_o (rx_right_o),
        .valid_o (rx_valid_o)
    );

endmodule

// File: rtl/i2s_master_xcvr_chk.sv
module i2s_master_xcvr_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_i,
    input logic             bclk_o,
    input logic             ws_o,
    input logic             sdo_o,
    input logic             tx_req_o,
    input logic             rx_valid_o
);

    logic           prev_q;
    logic [DIV_W:0] run_q;

    // Counts sampled cycles with an unchanged bit-clock level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            run_q  <= '0;
        end else begin
            prev_q <= bclk_o;
            if (bclk_o != prev_q) run_q <= (DIV_W+1)'(1);
            else                  run_q <= run_q + 1'b1;
        end
    end

    assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_o != prev_q) |-> (run_q == {1'b0, div_i} + 1'b1));

    assert_ws_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws_o) |-> $fell(bclk_o));

    assert_sdo_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_o) |-> $fell(bclk_o));

    assert_req_in_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |-> (!ws_o && $fell(bclk_o)));

    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_valid_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $rose(bclk_o));

endmodule

bind i2s_master_xcvr i2s_master_xcvr_chk #(.DIV_W(DIV_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_i      (div_i),
    .bclk_o     (bclk_o),
    .ws_o       (ws_o),
    .sdo_o      (sdo_o),
    .tx_req_o   (tx_req_o),
    .rx_valid_o (rx_valid_o)
);

// File: tb/i2s_master_xcvr_tb_top.sv
module i2s_master_xcvr_tb_top;
    import i2s_xcvr_pkg::*;

    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_i = '0;
    logic             fmt_i = 1'b0;
    logic [1:0]       width_i = 2'd3;
    logic [31:0]      tx_left_i = '0;
    logic [31:0]      tx_right_i = '0;
    logic             tx_load_i = 1'b0;
    logic             sdi_i;
    logic             bclk_o, ws_o, sdo_o, tx_req_o, rx_valid_o;
    logic [31:0]      rx_left_o, rx_right_o;

    // Loopback so the receiver sees what the transmitter drives (R3 sampling on rise).
    assign sdi_i = sdo_o;

    always #2 clk = ~clk;

    i2s_master_xcvr #(.DIV_W(DIV_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_i      (div_i),
        .fmt_i      (fmt_i),
        .width_i    (width_i),
        .tx_left_i  (tx_left_i),
        .tx_right_i (tx_right_i),
        .tx_load_i  (tx_load_i),
        .sdi_i      (sdi_i),
        .bclk_o     (bclk_o),
        .ws_o       (ws_o),
        .sdo_o      (sdo_o),
        .tx_req_o   (tx_req_o),
        .rx_left_o  (rx_left_o),
        .rx_right_o (rx_right_o),
        .rx_valid_o (rx_valid_o)
    );

    int          n_checks = 0;
    int          n_fail = 0;
    int unsigned cyc = 0;
    logic [63:0] txq[$];
    logic [63:0] rxq[$];

    always @(posedge clk) cyc = cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] wmask(input logic [1:0] c);
        case (c)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            2'd2:    return 32'h00FF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Line monitor: decodes the serial output from word-select edges.
    logic        prev_ws;
    int          k;
    logic [31:0] acc;
    logic [31:0] lw;
    bit          have_left, seen_tr, have_rise, per_done;
    int unsigned last_rise;

    always begin
        @(posedge bclk_o or negedge rst_n);
        if (!rst_n) begin
            prev_ws = 1'b1; k = 0; acc = '0; lw = '0;
            have_left = 0; seen_tr = 0; have_rise = 0; per_done = 0; last_rise = 0;
        end else begin
            int  w;
            int  j;
            logic ch;
            w = 8 * (int'(width_i) + 1);
            if (have_rise && !per_done) begin
                check((cyc - last_rise) == 2 * (int'(div_i) + 1), "R2 bit-clock period",
                      64'(cyc - last_rise), 64'(2 * (int'(div_i) + 1)));
                per_done = 1;
            end
            have_rise = 1;
            last_rise = cyc;
            if (ws_o != prev_ws) begin
                if (seen_tr) check(k == 31, "R4 slot length", 64'(k + 1), 64'd32);
                seen_tr = 1;
                k = 0;
            end else begin
                k++;
            end
            prev_ws = ws_o;
            if (fmt_i == FMT_I2S) begin
                if (k == 0) begin ch = ~ws_o; j = 31; end
                else        begin ch = ws_o;  j = k - 1; end
            end else begin
                ch = ws_o; j = k;
            end
            if (j < w) begin
                acc = (j == 0) ? {31'b0, sdo_o} : {acc[30:0], sdo_o};
                if (j == w - 1) begin
                    if (!ch) begin
                        lw = acc;
                        have_left = 1;
                    end else begin
                        if (have_left && txq.size() > 0) begin
                            logic [63:0] e;
                            e = txq.pop_front();
                            check({lw, acc} == e,
                                  (fmt_i == FMT_I2S) ? "R5 R6 R9 serial words" : "R5 R7 R9 serial words",
                                  {lw, acc}, e);
                        end
                        have_left = 0;
                    end
                end
            end else begin
                check(sdo_o == 1'b0, "R8 padding after LSB", 64'(sdo_o), 64'd0);
            end
        end
    end

    // Receive monitor: scoreboard of received pairs.
    always @(negedge clk) begin
        if (rst_n && rx_valid_o && rxq.size() > 0) begin
            logic [63:0] e;
            e = rxq.pop_front();
            check({rx_left_o, rx_right_o} == e, "R10 received pair", {rx_left_o, rx_right_o}, e);
        end
    end

    task automatic wait_req();
        do @(negedge clk); while (!tx_req_o);
    endtask

    task automatic run_cfg(input logic f, input logic [1:0] c, input logic [DIV_W-1:0] d, input logic [31:0] base);
        logic [31:0] pl, pr, m;
        @(negedge clk);
        rst_n = 1'b0;
        fmt_i = f; width_i = c; div_i = d; tx_load_i = 1'b0;
        repeat (3) @(negedge clk);
        check({bclk_o, ws_o, sdo_o, rx_valid_o, tx_req_o} == 5'b11000, "R1 reset state",
              64'({bclk_o, ws_o, sdo_o, rx_valid_o, tx_req_o}), 64'b11000);
        txq.delete();
        rxq.delete();
        pl = '0; pr = '0; m = wmask(c);
        rst_n = 1'b1;
        for (int fr = 0; fr < 6; fr++) begin
            wait_req();
            check(ws_o == 1'b0, "R9 request inside left slot", 64'(ws_o), 64'd0);
            txq.push_back({pl & m, pr & m});
            rxq.push_back({pl & m, pr & m});
            if (fr != 3) begin
                @(negedge clk);
                tx_left_i  = base ^ (32'h1357_9BDF * (fr + 1));
                tx_right_i = ~base + 32'h0F0F_3C3C * (fr + 1);
                tx_load_i  = 1'b1;
                @(negedge clk);
                tx_load_i = 1'b0;
                pl = tx_left_i;
                pr = tx_right_i;
            end
        end
        wait_req();
        check(txq.size() == 0, "R9 every frame sent", 64'(txq.size()), 64'd0);
        check(rxq.size() == 0, "R10 every frame received", 64'(rxq.size()), 64'd0);
    endtask

    initial begin
        run_cfg(FMT_I2S,       2'd3, 8'd1, 32'hC3A5_0F69);
        run_cfg(FMT_LEFT_JUST, 2'd1, 8'd2, 32'h8001_7FFE);
        run_cfg(FMT_I2S,       2'd0, 8'd1, 32'h5A96_81C3);
        run_cfg(FMT_LEFT_JUST, 2'd2, 8'd1, 32'hF0E1_D2C3);
        run_cfg(FMT_LEFT_JUST, 2'd3, 8'd0, 32'h9E37_79B9);
        run_cfg(FMT_I2S,       2'd1, 8'd3, 32'h2468_ACE1);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule